// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This block holds eight 16-bit pointer registers and a small dedicated adder that turns the currently selected register into a data-memory address. On each indirect access it emits the selected register's value as the address and, in the same clock cycle, post-modifies that register. The modify step can add or subtract one. It can also add or subtract the contents of register 0, which serves as the index step. The main arithmetic unit of the processor is never involved, so table walks cost it no cycles.

A 3-bit pointer chooses the current register. Software-style controls around the block can:

- reload the pointer;
- write any register directly;
- read any register back.

A direct write to the register being post-modified in the same cycle takes precedence over the modify result. A pointer reload issued together with an access affects only later accesses.

Top module: `aux_addr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all registers and the pointer clear to 0. After that edge `addr_out`, `addr_vld` and `rd_data` read 0.
- R2: One cycle after a cycle with `acc_en` high, `addr_vld` is 1 and `addr_out` holds the value the current register had before that edge, which is the pre-modify value. `addr_vld` is 0 after a cycle without `acc_en`.
- R3: Modify code 3'b001 adds 1 and 3'b010 subtracts 1 from the current register, modulo 65536.
- R4: Modify code 3'b011 adds and 3'b100 subtracts register 0's pre-edge value, modulo 65536. With register 0 current, 3'b011 doubles it.
- R5: Modify codes 3'b000 and 3'b101 to 3'b111 leave the current register unchanged.
- R6: `ptr_load` sets the pointer to `ptr_new` at the edge. An access in that same cycle still uses the old pointer.
- R7: When `wr_en` targets the register being post-modified in the same cycle, `wr_data` is stored and the modify result is discarded.
- R8: `wr_en` writes `wr_data` into register `wr_sel`. `rd_data` shows register `rd_sel`'s pre-edge value one cycle later.
- R9: Without `acc_en`, no register changes whatever `mod_code` is, and `addr_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Indirect access strobe |
| mod_code | input | 3 | Post-modify code |
| ptr_load | input | 1 | Reload the current-register pointer |
| ptr_new | input | 3 | New pointer value |
| wr_en | input | 1 | Direct register write |
| wr_sel | input | 3 | Register written |
| wr_data | input | 16 | Write value |
| rd_sel | input | 3 | Register read back |
| addr_out | output | 16 | Registered data address |
| addr_vld | output | 1 | Address valid for the access one cycle earlier |
| rd_data | output | 16 | Registered readback value |

## Verification
A wrong post-modify shows on `addr_out` at the very next access through the same register. It also shows on `rd_data` one cycle after that register is selected for readback. A wrong pointer appears as an address from the wrong register on the first access after the reload. A lost priority between a direct write and a modify shows as a readback differing from the written value. The bench reads a register back every cycle, so such faults surface within one to two cycles of the access that caused them.

// File: rtl/aux_addr_pkg.sv
package aux_addr_pkg;
  typedef enum logic [2:0] {
    MOD_NONE = 3'b000,
    MOD_INC  = 3'b001,
    MOD_DEC  = 3'b010,
    MOD_ADDX = 3'b011,
    MOD_SUBX = 3'b100
  } mod_code_e;
endpackage

// File: rtl/aux_ptr_reg.sv
module aux_ptr_reg #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] new_ptr,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= new_ptr;
  end
endmodule

// File: rtl/aux_step_calc.sv
module aux_step_calc
  import aux_addr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic [2:0]    code,
  output logic [DW-1:0] next_val,
  output logic          changes
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    next_val = base;
    changes  = 1'b1;
    case (code)
      MOD_INC:  next_val = base + ONE;
      MOD_DEC:  next_val = base - ONE;
      MOD_ADDX: next_val = base + idx;
      MOD_SUBX: next_val = base - idx;
      default:  changes  = 1'b0;
    endcase
  end
endmodule

// File: rtl/aux_reg_bank.sv
module aux_reg_bank #(
  parameter int DW = 16,
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [PW-1:0] upd_sel,
  input  logic [DW-1:0] upd_val,
  input  logic          ld_en,
  input  logic [PW-1:0] ld_sel,
  input  logic [DW-1:0] ld_val,
  input  logic [PW-1:0] cur_sel,
  output logic [DW-1:0] cur_val,
  output logic [DW-1:0] idx_val,
  input  logic [PW-1:0] rd_sel,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    // explicit load takes priority over post-modify
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (ld_en && ld_sel == PW'(i))
        regs[i] <= ld_val;
      else if (upd_en && upd_sel == PW'(i))
        regs[i] <= upd_val;
    end
  end

  assign cur_val = regs[cur_sel];
  assign idx_val = regs[0];

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= regs[rd_sel];
  end
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic [2:0]        mod_code,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  ptr_new,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] addr_out,
  output logic              addr_vld,
  output logic [DATA_W-1:0] rd_data
);
  logic [PTR_W-1:0]  cur_ptr;
  logic [DATA_W-1:0] cur_val, idx_val, next_val;
  logic              changes;

  aux_ptr_reg #(.PW(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .new_ptr(ptr_new), .ptr(cur_ptr)
  );

  aux_step_calc #(.DW(DATA_W)) u_calc (
    .base(cur_val), .idx(idx_val), .code(mod_code),
    .next_val(next_val), .changes(changes)
  );

  aux_reg_bank #(.DW(DATA_W), .N(NUM_REGS), .PW(PTR_W)) u_bank (
    .clk(clk), .rst(rst),
    .upd_en(acc_en && changes), .upd_sel(cur_ptr), .upd_val(next_val),
    .ld_en(wr_en), .ld_sel(wr_sel), .ld_val(wr_data),
    .cur_sel(cur_ptr), .cur_val(cur_val), .idx_val(idx_val),
    .rd_sel(rd_sel), .rd_q(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_en;
      if (acc_en) addr_out <= cur_val;
    end
  end
endmodule

// File: rtl/aux_addr_unit_chk.sv
module aux_addr_unit_chk #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              ptr_load,
  input logic [PTR_W-1:0]  ptr_new,
  input logic [PTR_W-1:0]  cur_ptr,
  input logic [DATA_W-1:0] addr_out,
  input logic              addr_vld
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!addr_vld && addr_out == '0 && cur_ptr == '0));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_vld);

  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !addr_vld);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(addr_out));

  // R6
  ptr_reload_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> cur_ptr == $past(ptr_new));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ptr_load |=> $stable(cur_ptr));
endmodule

bind aux_addr_unit aux_addr_unit_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .ptr_load(ptr_load),
  .ptr_new(ptr_new), .cur_ptr(cur_ptr), .addr_out(addr_out), .addr_vld(addr_vld)
);

// File: tb/aux_addr_unit_test.sv
module aux_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic [2:0]  mod_code = '0;
  logic        ptr_load = 1'b0;
  logic [2:0]  ptr_new = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] addr_out, rd_data;
  logic        addr_vld;

  always #2.5 clk = ~clk;

  aux_addr_unit uut (.*);

  typedef struct {
    logic        vld;
    logic [15:0] addr;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] m [8];
  logic [2:0]  mp;
  logic [15:0] last_addr;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  task automatic step(input bit r, input bit a, input logic [2:0] c,
                      input bit pl, input logic [2:0] pn,
                      input bit we, input logic [2:0] ws, input logic [15:0] wd,
                      input logic [2:0] rs, input string tag);
    exp_t e;
    logic [15:0] b, x, nv;
    bit ch;
    @(negedge clk);
    rst = r; acc_en = a; mod_code = c; ptr_load = pl; ptr_new = pn;
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    if (r) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      mp = '0; last_addr = '0;
      e.vld = 1'b0; e.addr = '0; e.rd = '0;
    end else begin
      b = m[mp]; x = m[0]; ch = 1'b1;
      case (c)
        3'b001: nv = b + 16'd1;
        3'b010: nv = b - 16'd1;
        3'b011: nv = b + x;
        3'b100: nv = b - x;
        default: begin nv = b; ch = 1'b0; end
      endcase
      e.vld = a;
      if (a) last_addr = b;
      e.addr = last_addr;
      e.rd = m[rs];
      if (a && ch) m[mp] = nv;
      if (we) m[ws] = wd;
      if (pl) mp = pn;
    end
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input logic [2:0] rs, input string tag);
    step(0, 0, 3'b000, 0, 3'd0, 0, 3'd0, 16'd0, rs, tag);
  endtask

  task automatic acc(input logic [2:0] c, input logic [2:0] rs, input string tag);
    step(0, 1, c, 0, 3'd0, 0, 3'd0, 16'd0, rs, tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d, input string tag);
    step(0, 0, 3'b000, 0, 3'd0, 1, s, d, s, tag);
  endtask

  task automatic setp(input logic [2:0] p, input string tag);
    step(0, 0, 3'b000, 1, p, 0, 3'd0, 16'd0, 3'd0, tag);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (addr_vld !== e.vld || addr_out !== e.addr || rd_data !== e.rd) begin
          n_bad++;
          $display("FAIL %s: vld=%0b addr=%h rd=%h expected vld=%0b addr=%h rd=%h",
                   e.tag, addr_vld, addr_out, rd_data, e.vld, e.addr, e.rd);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step(1, 0, 3'b000, 0, 3'd0, 0, 3'd0, 16'd0, 3'd0, "R1");
    step(1, 1, 3'b001, 1, 3'd5, 1, 3'd2, 16'h1234, 3'd2, "R1");
    idle(3'd5, "R1");
    // R8 writes and readback
    wr(3'd0, 16'h0003, "R8");
    wr(3'd1, 16'h0010, "R8");
    wr(3'd2, 16'hFFFF, "R8");
    wr(3'd3, 16'h0000, "R8");
    wr(3'd4, 16'h8000, "R8");
    wr(3'd7, 16'hA5A5, "R8");
    idle(3'd7, "R8");
    // R6 pointer to 1
    setp(3'd1, "R6");
    // R2/R3 increment and decrement
    acc(3'b001, 3'd1, "R3");
    acc(3'b001, 3'd1, "R2");
    acc(3'b010, 3'd1, "R3");
    acc(3'b010, 3'd1, "R3");
    // R4 index modify
    acc(3'b011, 3'd1, "R4");
    acc(3'b011, 3'd1, "R4");
    acc(3'b100, 3'd1, "R4");
    idle(3'd1, "R4");
    // R3 wrap
    setp(3'd2, "R6");
    acc(3'b001, 3'd2, "R3");
    acc(3'b000, 3'd2, "R3");
    setp(3'd3, "R6");
    acc(3'b010, 3'd3, "R3");
    acc(3'b000, 3'd3, "R3");
    // R4 wrap with subtract
    setp(3'd4, "R6");
    wr(3'd0, 16'h9000, "R4");
    acc(3'b011, 3'd4, "R4");
    acc(3'b100, 3'd4, "R4");
    idle(3'd4, "R4");
    // R5 no-change codes
    acc(3'b000, 3'd4, "R5");
    acc(3'b101, 3'd4, "R5");
    acc(3'b110, 3'd4, "R5");
    acc(3'b111, 3'd4, "R5");
    idle(3'd4, "R5");
    // R6 reload during access: old pointer used
    step(0, 1, 3'b001, 1, 3'd7, 0, 3'd0, 16'd0, 3'd4, "R6");
    acc(3'b001, 3'd7, "R6");
    idle(3'd7, "R6");
    // R7 write wins over modify on same register
    step(0, 1, 3'b001, 0, 3'd0, 1, 3'd7, 16'h0123, 3'd7, "R7");
    idle(3'd7, "R7");
    acc(3'b000, 3'd7, "R7");
    // R9 no access, modify code present
    step(0, 0, 3'b011, 0, 3'd0, 0, 3'd0, 16'd0, 3'd7, "R9");
    step(0, 0, 3'b001, 0, 3'd0, 0, 3'd0, 16'd0, 3'd7, "R9");
    idle(3'd7, "R9");
    // R4 doubling register 0
    wr(3'd0, 16'h0005, "R4");
    setp(3'd0, "R6");
    acc(3'b011, 3'd0, "R4");
    acc(3'b011, 3'd0, "R4");
    idle(3'd0, "R4");
    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      step(0, 1'($urandom), 3'($urandom), 1'($urandom_range(0, 3) == 0), 3'($urandom),
           1'($urandom_range(0, 3) == 0), 3'($urandom), 16'($urandom), 3'($urandom), "R2");
    end
    idle(3'd0, "R2");
    idle(3'd0, "R2");
    @(posedge clk); #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule